// File: doc/BRIEF.md
# Byte-Lane Steering Data Buffer

This block is the data path of a bridge between a 32-bit host data bus and a four-lane expansion data bus whose devices may sit on only one or two of the byte lanes. It holds two separate groups of byte latches. One group captures a whole host word. The other captures the expansion lanes one lane at a time. A fixed set of lane-to-lane copy paths moves bytes between lanes so that a narrow device on the low lanes can reach every byte of a word. All controls are active-low strobes that come from an outside sequencer. The block only carries out what those strobes select, one clock at a time.

Tri-state lanes are modelled as separate value, drive-enable and external-drive vectors. Each expansion lane resolves to a single effective byte by a fixed priority. First comes an outside driver, then the buffer's own output drive, then a copy path. The lane latches capture that effective byte. Write data goes from the host latches out onto the expansion lanes. Read data gathered in the lane latches goes back to the host in half-word groups. The copy paths cover exactly four lane pairs and share one direction bit.

Top module: `lane_steer_buffer`

## Requirements
- R1: After reset every latch holds zero, and with no strobe active `lane_oe` is 0, `lane_out` is 0 and `contend` is 0.
- R2: While `host_le_n` is low at a rising clock edge, all four host latch bytes load `host_in`. While it is high, they hold their value.
- R3: Lane latch i loads the effective byte of lane i at a rising edge while `lane_le_n[i]` is low, and holds otherwise. Each lane's strobe is independent of the others.
- R4: `lane_drv_n[0]` drives host latch byte 0 onto lane 0 and `lane_drv_n[1]` drives byte 1 onto lane 1. `lane_drv_n[2]` drives bytes 2 and 3 onto lanes 2 and 3 together. `lane_oe[i]` is 1 for each lane the buffer drives or a copy path targets.
- R5: `host_drv_n[0]` low drives lane latches 0 and 1 onto host bytes 0-1, and `host_drv_n[1]` low drives lane latches 2 and 3 onto host bytes 2-3. A host byte that is not driven has `host_oe` 0 and reads 0.
- R6: `cpy_n` bits select the pairs bit0 = lanes 0/1, bit1 = 0/2, bit2 = 0/3 and bit3 = 1/3. With `cpy_up` high, an enabled pair moves the byte of its lower lane onto its higher lane.
- R7: With `cpy_up` low, an enabled pair moves the byte of its higher lane onto its lower lane. This lets a driven upper lane be read on lane 0 or on lanes 0-1.
- R8: The effective byte of a lane is taken from the first present source in this order: the external driver (`lane_ext`), then the buffer drive, then a copy path.
- R9: `contend` is 1 in any cycle in which a lane has two or more internal sources: the buffer drive plus a copy, or two copies.
- R10: A copy carries its source lane's external or buffer-driven byte, or zero if the source lane has neither, so copies never chain. When several copies target one lane, the lowest-numbered enabled pair supplies the byte.
- R11: `lane_out` is zero on every lane whose `lane_oe` bit is 0. Where the buffer drives a lane, `lane_out` carries the buffer byte even when a copy also targets that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all latches load on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_in | input | 32 | Host data bus as seen by the buffer |
| host_le_n | input | 1 | Active-low strobe loading all four host bytes |
| host_drv_n | input | 2 | Active-low host drive: bit0 bytes 0-1, bit1 bytes 2-3 |
| host_out | output | 32 | Lane latch bytes presented to the host bus |
| host_oe | output | 4 | Per-byte host bus drive enable |
| lane_in | input | 32 | Byte values put on the lanes by outside devices |
| lane_ext | input | 4 | Per-lane flag: an outside device drives the lane |
| lane_le_n | input | 4 | Active-low per-lane latch strobes |
| lane_drv_n | input | 3 | Active-low buffer drive: lane 0, lane 1, lanes 2-3 |
| cpy_n | input | 4 | Active-low copy enables for pairs 0/1, 0/2, 0/3, 1/3 |
| cpy_up | input | 1 | Copy direction: 1 lower to higher, 0 higher to lower |
| lane_out | output | 32 | Bytes the buffer puts on the lanes |
| lane_oe | output | 4 | Per-lane buffer drive enable |
| contend | output | 1 | Two internal sources target one lane this cycle |

## Verification
The bench sweeps every copy-enable pattern in both directions against every external-drive mask and several buffer-drive patterns. It compares lane values, enables and the contention flag against an arithmetic model, then captures the lanes into the lane latches and reads them back through the host side. The sweep targets these faults: a pair wired to the wrong lane, a reversed direction bit, a copy reading another copy's result, a wrong priority between the outside driver and the buffer drive, and a lanes 2-3 drive that enables only one lane. Each of these shows up as a wrong byte on a lane or in a latch. A missing clash term shows up as a `contend` that stays low, for example when copies 0/3 and 1/3 both target lane 3. Smaller directed cases check that strobes that are not asserted leave the latches alone, and that each host half-word drive stays inside its own two bytes.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
   // number of expansion byte lanes served by the copy network
   localparam int LANES = 4;
   // number of dedicated lane-to-lane copy paths
   localparam int NPAIR = 4;

   // lower lane of copy pair p (order matters: it is the cpy_n bit order)
   function automatic int pair_lo(input int p);
      case (p)
         0, 1, 2: return 0;
         default: return 1;
      endcase
   endfunction

   // higher lane of copy pair p
   function automatic int pair_hi(input int p);
      case (p)
         0:       return 1;
         1:       return 2;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/lsb_latch_bank.sv
module lsb_latch_bank #(
   parameter int NBYTE  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NBYTE-1:0]        le_n,
   input  logic [NBYTE*BYTE_W-1:0] d,
   output logic [NBYTE*BYTE_W-1:0] q
);
   generate
      if (NBYTE < 1) begin : g_bad_nbyte
         $error("lsb_latch_bank: NBYTE must be at least 1");
      end
      if (BYTE_W < 1) begin : g_bad_bw
         $error("lsb_latch_bank: BYTE_W must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[b*BYTE_W +: BYTE_W] <= '0;
         else if (!le_n[b])
            q[b*BYTE_W +: BYTE_W] <= d[b*BYTE_W +: BYTE_W];
      end

      // R2 R3
      latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         le_n[b] |=> $stable(q[b*BYTE_W +: BYTE_W]));

      // R2 R3
      latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !le_n[b] |=> q[b*BYTE_W +: BYTE_W] == $past(d[b*BYTE_W +: BYTE_W]));
   end
endmodule

// File: rtl/lsb_copy_net.sv
module lsb_copy_net
   import lsb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        prim_vld,
   input  logic [LANES*BYTE_W-1:0] prim_val,
   input  logic [NPAIR-1:0]        cpy_n,
   input  logic                    cpy_up,
   output logic [LANES-1:0]        cp_vld,
   output logic [LANES-1:0]        cp_multi,
   output logic [LANES*BYTE_W-1:0] cp_val
);
   for (genvar t = 0; t < LANES; t++) begin : g_tgt
      always_comb begin
         int src;
         int tgt;
         int hits;
         hits = 0;
         cp_val[t*BYTE_W +: BYTE_W] = '0;
         for (int p = 0; p < NPAIR; p++) begin
            tgt = cpy_up ? pair_hi(p) : pair_lo(p);
            src = cpy_up ? pair_lo(p) : pair_hi(p);
            if (!cpy_n[p] && tgt == t) begin
               // lowest enabled pair supplies the byte; sources are primaries only
               if (hits == 0 && prim_vld[src])
                  cp_val[t*BYTE_W +: BYTE_W] = prim_val[src*BYTE_W +: BYTE_W];
               hits = hits + 1;
            end
         end
         cp_vld[t]   = (hits != 0);
         cp_multi[t] = (hits > 1);
      end
   end

   // R6 R7
   copy_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cp_vld) <= $countones(~cpy_n));

   // R9
   copy_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_multi != '0) |-> ($countones(~cpy_n) >= 2));
endmodule

// File: rtl/lsb_lane_mux.sv
module lsb_lane_mux #(
   parameter int BYTE_W = 8
) (
   input  logic              ext_on,
   input  logic [BYTE_W-1:0] ext_val,
   input  logic              buf_on,
   input  logic [BYTE_W-1:0] buf_val,
   input  logic              cp_on,
   input  logic              cp_multi,
   input  logic [BYTE_W-1:0] cp_val,
   output logic [BYTE_W-1:0] eff,
   output logic [BYTE_W-1:0] drv_val,
   output logic              drv_oe,
   output logic              clash
);
   always_comb begin
      drv_oe  = buf_on | cp_on;
      drv_val = buf_on ? buf_val : (cp_on ? cp_val : '0);
      if (ext_on)      eff = ext_val;
      else if (buf_on) eff = buf_val;
      else if (cp_on)  eff = cp_val;
      else             eff = '0;
      clash = (buf_on & cp_on) | cp_multi;
   end
endmodule

// File: rtl/lane_steer_buffer.sv
module lane_steer_buffer
   import lsb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [4*BYTE_W-1:0]     host_in,
   input  logic                    host_le_n,
   input  logic [1:0]              host_drv_n,
   output logic [4*BYTE_W-1:0]     host_out,
   output logic [3:0]              host_oe,
   input  logic [4*BYTE_W-1:0]     lane_in,
   input  logic [3:0]              lane_ext,
   input  logic [3:0]              lane_le_n,
   input  logic [2:0]              lane_drv_n,
   input  logic [3:0]              cpy_n,
   input  logic                    cpy_up,
   output logic [4*BYTE_W-1:0]     lane_out,
   output logic [3:0]              lane_oe,
   output logic                    contend
);
   localparam int WORD_W = LANES * BYTE_W;

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("lane_steer_buffer: copy pairs assume four lanes");
      end
   endgenerate

   logic [WORD_W-1:0] host_q, lane_q, eff, prim_val, cp_val;
   logic [LANES-1:0]  buf_on, prim_vld, cp_vld, cp_multi, clash;

   assign buf_on = {~lane_drv_n[2], ~lane_drv_n[2], ~lane_drv_n[1], ~lane_drv_n[0]};

   lsb_latch_bank #(.NBYTE(LANES), .BYTE_W(BYTE_W)) u_host_bank (
      .clk(clk), .rst_n(rst_n), .le_n({LANES{host_le_n}}), .d(host_in), .q(host_q));

   lsb_latch_bank #(.NBYTE(LANES), .BYTE_W(BYTE_W)) u_lane_bank (
      .clk(clk), .rst_n(rst_n), .le_n(lane_le_n), .d(eff), .q(lane_q));

   for (genvar l = 0; l < LANES; l++) begin : g_prim
      assign prim_vld[l] = lane_ext[l] | buf_on[l];
      assign prim_val[l*BYTE_W +: BYTE_W] = lane_ext[l] ? lane_in[l*BYTE_W +: BYTE_W]
                                                        : host_q[l*BYTE_W +: BYTE_W];
   end

   lsb_copy_net #(.BYTE_W(BYTE_W)) u_copy (
      .clk(clk), .rst_n(rst_n), .prim_vld(prim_vld), .prim_val(prim_val),
      .cpy_n(cpy_n), .cpy_up(cpy_up), .cp_vld(cp_vld), .cp_multi(cp_multi),
      .cp_val(cp_val));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      lsb_lane_mux #(.BYTE_W(BYTE_W)) u_mux (
         .ext_on(lane_ext[l]), .ext_val(lane_in[l*BYTE_W +: BYTE_W]),
         .buf_on(buf_on[l]), .buf_val(host_q[l*BYTE_W +: BYTE_W]),
         .cp_on(cp_vld[l]), .cp_multi(cp_multi[l]), .cp_val(cp_val[l*BYTE_W +: BYTE_W]),
         .eff(eff[l*BYTE_W +: BYTE_W]), .drv_val(lane_out[l*BYTE_W +: BYTE_W]),
         .drv_oe(lane_oe[l]), .clash(clash[l]));
   end

   assign contend = |clash;

   for (genvar h = 0; h < 2; h++) begin : g_host_half
      assign host_oe[2*h +: 2] = {2{~host_drv_n[h]}};
      assign host_out[2*h*BYTE_W +: 2*BYTE_W] =
         host_drv_n[h] ? '0 : lane_q[2*h*BYTE_W +: 2*BYTE_W];
   end

   // R9
   contend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      contend |-> (cpy_n != 4'hF));

   // R5
   host_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_oe[0] == host_oe[1]) && (host_oe[2] == host_oe[3]));

   // R4
   lane_pair_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_drv_n[2] |-> (lane_oe[2] && lane_oe[3]));
endmodule

// File: tb/lane_steer_buffer_test.sv
module lane_steer_buffer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] host_in = '0;
   logic        host_le_n = 1'b1;
   logic [1:0]  host_drv_n = 2'b11;
   logic [31:0] host_out;
   logic [3:0]  host_oe;
   logic [31:0] lane_in = '0;
   logic [3:0]  lane_ext = '0;
   logic [3:0]  lane_le_n = 4'hF;
   logic [2:0]  lane_drv_n = 3'b111;
   logic [3:0]  cpy_n = 4'hF;
   logic        cpy_up = 1'b0;
   logic [31:0] lane_out;
   logic [3:0]  lane_oe;
   logic        contend;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [31:0] HOST_W = 32'hA1B2C3D4;
   localparam logic [31:0] LANE_W = 32'h5566E788;
   int lo_t[4] = '{0, 0, 0, 1};
   int hi_t[4] = '{1, 2, 3, 3};

   always #4 clk = ~clk;

   lane_steer_buffer uut (
      .clk(clk), .rst_n(rst_n), .host_in(host_in), .host_le_n(host_le_n),
      .host_drv_n(host_drv_n), .host_out(host_out), .host_oe(host_oe),
      .lane_in(lane_in), .lane_ext(lane_ext), .lane_le_n(lane_le_n),
      .lane_drv_n(lane_drv_n), .cpy_n(cpy_n), .cpy_up(cpy_up),
      .lane_out(lane_out), .lane_oe(lane_oe), .contend(contend));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // arithmetic model of the lanes built from the requirements
   task automatic model(input logic [3:0] ext, input logic [2:0] drvn, input logic [3:0] cpn,
                        input logic up, input logic [31:0] hl,
                        output logic [31:0] eff, output logic [31:0] out,
                        output logic [3:0] oe, output logic ct);
      logic [3:0] bon;
      bon = {~drvn[2], ~drvn[2], ~drvn[1], ~drvn[0]};
      eff = '0; out = '0; oe = '0; ct = 1'b0;
      for (int t = 0; t < 4; t++) begin
         int n;
         logic [7:0] cv;
         n = 0; cv = 8'h00;
         for (int p = 0; p < 4; p++) begin
            int tg;
            int sr;
            tg = up ? hi_t[p] : lo_t[p];
            sr = up ? lo_t[p] : hi_t[p];
            if (!cpn[p] && tg == t) begin
               if (n == 0)
                  cv = ext[sr] ? LANE_W[sr*8 +: 8] : (bon[sr] ? hl[sr*8 +: 8] : 8'h00);
               n++;
            end
         end
         if (n + int'(bon[t]) >= 2) ct = 1'b1;
         oe[t] = bon[t] || n > 0;
         out[t*8 +: 8] = bon[t] ? hl[t*8 +: 8] : (n > 0 ? cv : 8'h00);
         eff[t*8 +: 8] = ext[t] ? LANE_W[t*8 +: 8] : out[t*8 +: 8];
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] e_eff, e_out;
      logic [3:0]  e_oe;
      logic        e_ct;
      lane_in = LANE_W;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      host_drv_n = 2'b00;
      #1;
      check("R1", host_out, 32'h0);
      check("R1", {28'h0, lane_oe}, 32'h0);
      check("R1", lane_out, 32'h0);
      check("R1", {31'h0, contend}, 32'h0);

      // R2 host load then hold
      @(negedge clk); host_in = HOST_W; host_le_n = 1'b0;
      @(negedge clk); host_le_n = 1'b1; host_in = 32'h0BAD0BAD; lane_drv_n = 3'b000;
      #1 check("R2", lane_out, HOST_W);
      @(negedge clk); #1 check("R2", lane_out, HOST_W);
      lane_drv_n = 3'b111;

      // R3 single-lane strobe leaves other lanes alone
      lane_ext = 4'hF;
      @(negedge clk); lane_le_n = 4'b1011;
      @(negedge clk); lane_le_n = 4'hF; lane_ext = 4'h0;
      #1 check("R3", host_out, {8'h00, LANE_W[23:16], 16'h0000});

      // R5 host halves
      host_drv_n = 2'b10;
      #1 check("R5", {28'h0, host_oe}, 32'h3);
      check("R5", host_out, 32'h0);
      host_drv_n = 2'b01;
      #1 check("R5", {28'h0, host_oe}, 32'hC);
      check("R5", host_out, {8'h00, LANE_W[23:16], 16'h0000});
      host_drv_n = 2'b00;

      // R11 undriven lanes read zero with only lane 1 driven
      lane_drv_n = 3'b101;
      #1 check("R11", lane_out, {16'h0, HOST_W[15:8], 8'h00});
      check("R4", {28'h0, lane_oe}, 32'h2);

      // combinational sweep: R4 R6 R7 R9 R11
      for (int up = 0; up < 2; up++)
         for (int c = 0; c < 16; c++)
            for (int d = 0; d < 8; d++)
               for (int x = 0; x < 16; x++) begin
                  cpy_up = up[0]; cpy_n = c[3:0]; lane_drv_n = d[2:0]; lane_ext = x[3:0];
                  #1;
                  model(x[3:0], d[2:0], c[3:0], up[0], HOST_W, e_eff, e_out, e_oe, e_ct);
                  check("R4", {28'h0, lane_oe}, {28'h0, e_oe});
                  check(up ? "R6 R11" : "R7 R11", lane_out, e_out);
                  check("R9", {31'h0, contend}, {31'h0, e_ct});
               end

      // capture sweep through the lane latches: R3 R8 R10
      for (int up = 0; up < 2; up++)
         for (int c = 0; c < 16; c++)
            for (int di = 0; di < 4; di++)
               for (int x = 0; x < 16; x++) begin
                  logic [2:0] dv;
                  dv = (di == 0) ? 3'b111 : (di == 1) ? 3'b101 : (di == 2) ? 3'b010 : 3'b000;
                  @(negedge clk);
                  cpy_up = up[0]; cpy_n = c[3:0]; lane_drv_n = dv; lane_ext = x[3:0];
                  lane_le_n = 4'h0;
                  model(x[3:0], dv, c[3:0], up[0], HOST_W, e_eff, e_out, e_oe, e_ct);
                  @(negedge clk);
                  lane_le_n = 4'hF;
                  #1 check("R8 R10", host_out, e_eff);
               end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule